// File: doc/BRIEF.md
# Indirectly Addressed GPIO Port

This block is one general-purpose I/O port with a small register interface of four byte locations. Three of them are plain registers: an index register, a read-only input data register and an output data register. The fourth is a shared configuration window. It does not hold data itself. Each access to the window is routed to the configuration subregister that the index register selects. Software first writes an index into the index register. It then reads or writes the window. Only index 01h is implemented, and it selects the pin direction subregister.

Each pin is an output when its direction bit is 0 and an input when the bit is 1. An output pin drives the matching output data bit. An input pin has its driver switched off. A per-pin alternate-function enable hands the pin's output enable and output value to external alternate-function inputs, and the direction bit then has no effect on that pin.

Pin inputs pass through a two-flop synchronizer and are then captured into the input data register. Reset is asynchronous and active-low, and its release is synchronized to the clock.

Top module: `gpio_indirect_port`

## Requirements
- R1: After reset the index register and the output data register read 00h, every direction bit is 1, every pin_oe bit is 0, and a window read returns 00h.
- R2: Location offset 0 is the 8-bit index register. A write there is visible on reads after the clock edge that samples the write strobe.
- R3: While the index register holds 01h, the window at offset 1 reads and writes the direction subregister. A write takes effect on the edge that samples the strobe.
- R4: While the index register holds any value other than 01h, window writes change no state and window reads return 00h.
- R5: A pin with alt_en 0 and direction bit 0 has pin_oe 1 and drives pin_out equal to its output data bit.
- R6: A pin with alt_en 0 and direction bit 1 has pin_oe 0, so its driver is tri-stated.
- R7: A pin with alt_en 1 takes pin_oe from alt_oe and pin_out from alt_out, whatever its direction bit holds.
- R8: The input data register at offset 2 shows a pin_in change after exactly three clock edges. Writes to offset 2 change no register.
- R9: Offset 3 is the output data register and can be read and written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register interface |
| reg_off | input | 2 | Register offset: 0 index, 1 window, 2 input data, 3 output data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_off (combinational) |
| pin_in | input | 8 | Raw pin levels, asynchronous to clk |
| pin_oe | output | 8 | Per-pin output driver enable |
| pin_out | output | 8 | Per-pin output value |
| alt_en | input | 8 | Per-pin alternate-function enable |
| alt_oe | input | 8 | Alternate-function output enable |
| alt_out | input | 8 | Alternate-function output value |

## Verification
A wrong index register or a wrong window decode shows up on the next window read. It can appear either as nonzero data for an unimplemented index or as a direction value that a write aimed elsewhere has changed. A corrupted direction bit reaches pin_oe in the same cycle as the faulty register update, because the pin multiplexer is purely combinational. A synchronizer stage that is missing or added shifts the input data read by one cycle, so the bench samples that read both two and three edges after a pin change.

// File: rtl/gpio_ind_pkg.sv
package gpio_ind_pkg;
  typedef enum logic [1:0] {
    OFF_INDEX = 2'd0,
    OFF_WINDOW = 2'd1,
    OFF_INDATA = 2'd2,
    OFF_OUTDATA = 2'd3
  } reg_off_e;

  localparam logic [7:0] SUB_DIRECTION = 8'h01;
endpackage

// File: rtl/gpio_ind_regs.sv
module gpio_ind_regs
  import gpio_ind_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        off_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] indata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] dir_o,
  output logic [DATA_W-1:0] outdata_o
);
  logic [7:0]        index_q, index_d;
  logic [DATA_W-1:0] dir_q, dir_d;
  logic [DATA_W-1:0] odr_q, odr_d;
  logic              dir_sel;
  reg_off_e          off;

  assign off     = reg_off_e'(off_i);
  assign dir_sel = (index_q == SUB_DIRECTION);

  always_comb begin
    index_d = index_q;
    dir_d   = dir_q;
    odr_d   = odr_q;
    if (wr_i) begin
      case (off)
        OFF_INDEX:   index_d = wdata_i[7:0];
        OFF_WINDOW:  if (dir_sel) dir_d = wdata_i;
        OFF_OUTDATA: odr_d = wdata_i;
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      index_q <= 8'h00;
      dir_q   <= {DATA_W{1'b1}};
      odr_q   <= '0;
    end else begin
      index_q <= index_d;
      dir_q   <= dir_d;
      odr_q   <= odr_d;
    end
  end

  always_comb begin
    case (off)
      OFF_INDEX:   rdata_o = DATA_W'(index_q);
      OFF_WINDOW:  rdata_o = dir_sel ? dir_q : '0;
      OFF_INDATA:  rdata_o = indata_i;
      default:     rdata_o = odr_q;
    endcase
  end

  assign dir_o     = dir_q;
  assign outdata_o = odr_q;

  AST_INDEX_WRITE: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_i && off_i == 2'd0) |=> (index_q == $past(wdata_i[7:0]))); // R2
  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_i && off_i == 2'd1 && index_q == 8'h01) |=> (dir_q == $past(wdata_i))); // R3
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !(wr_i && off_i == 2'd1 && index_q == 8'h01) |=> $stable(dir_q)); // R4
  AST_WINDOW_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    (off_i == 2'd1 && index_q != 8'h01) |-> (rdata_o == '0)); // R4
  AST_INDATA_RO: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_i && off_i == 2'd2) |=> ($stable(index_q) && $stable(odr_q))); // R8
  AST_ODR_WRITE: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_i && off_i == 2'd3) |=> (odr_q == $past(wdata_i))); // R9
endmodule

// File: rtl/gpio_ind_sync.sv
module gpio_ind_sync #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] pin_i,
  output logic [DATA_W-1:0] indata_o
);
  logic [DATA_W-1:0] meta_q, stab_q, idr_q;
  logic [1:0]        age_q, age_d;

  always_comb begin
    age_d = age_q;
    if (age_q != 2'd3) age_d = age_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      stab_q <= '0;
      idr_q  <= '0;
      age_q  <= 2'd0;
    end else begin
      meta_q <= pin_i;
      stab_q <= meta_q;
      idr_q  <= stab_q;
      age_q  <= age_d;
    end
  end

  assign indata_o = idr_q;

  AST_IN_LATENCY: assert property (@(posedge clk) disable iff (!rst_ni)
    (age_q == 2'd3) |-> (indata_o == $past(pin_i, 3))); // R8
endmodule

// File: rtl/gpio_ind_pinmux.sv
module gpio_ind_pinmux #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] dir_i,
  input  logic [DATA_W-1:0] outdata_i,
  input  logic [DATA_W-1:0] alt_en_i,
  input  logic [DATA_W-1:0] alt_oe_i,
  input  logic [DATA_W-1:0] alt_out_i,
  output logic [DATA_W-1:0] oe_o,
  output logic [DATA_W-1:0] out_o
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_pin
    always_comb begin
      if (alt_en_i[i]) begin
        oe_o[i]  = alt_oe_i[i];
        out_o[i] = alt_out_i[i];
      end else begin
        oe_o[i]  = ~dir_i[i];
        out_o[i] = outdata_i[i];
      end
    end
  end

  AST_INPUT_TRISTATE: assert property (@(posedge clk) disable iff (!rst_ni)
    ((oe_o & dir_i & ~alt_en_i) == '0)); // R6
  AST_ALT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_ni)
    (((oe_o ^ alt_oe_i) & alt_en_i) == '0)); // R7
endmodule

// File: rtl/gpio_indirect_port.sv
module gpio_indirect_port #(
  parameter int PIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_off,
  input  logic [PIN_W-1:0] reg_wdata,
  output logic [PIN_W-1:0] reg_rdata,
  input  logic [PIN_W-1:0] pin_in,
  output logic [PIN_W-1:0] pin_oe,
  output logic [PIN_W-1:0] pin_out,
  input  logic [PIN_W-1:0] alt_en,
  input  logic [PIN_W-1:0] alt_oe,
  input  logic [PIN_W-1:0] alt_out
);
  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic [PIN_W-1:0] dir, odr, idr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  gpio_ind_regs #(.DATA_W(PIN_W)) u_regs (
    .clk(clk), .rst_ni(rst_int_n), .wr_i(reg_wr), .off_i(reg_off),
    .wdata_i(reg_wdata), .indata_i(idr), .rdata_o(reg_rdata),
    .dir_o(dir), .outdata_o(odr)
  );

  gpio_ind_sync #(.DATA_W(PIN_W)) u_sync (
    .clk(clk), .rst_ni(rst_int_n), .pin_i(pin_in), .indata_o(idr)
  );

  gpio_ind_pinmux #(.DATA_W(PIN_W)) u_mux (
    .clk(clk), .rst_ni(rst_int_n), .dir_i(dir), .outdata_i(odr),
    .alt_en_i(alt_en), .alt_oe_i(alt_oe), .alt_out_i(alt_out),
    .oe_o(pin_oe), .out_o(pin_out)
  );

  AST_OUT_DRIVE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (((pin_out ^ odr) & ~dir & ~alt_en) == '0)); // R5
endmodule

// File: tb/gpio_indirect_port_bench.sv
`timescale 1ns/1ps
module gpio_indirect_port_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [1:0] reg_off;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] pin_in, pin_oe, pin_out, alt_en, alt_oe, alt_out;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  gpio_indirect_port u_gpio_indirect_port (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_off(reg_off),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .alt_en(alt_en),
    .alt_oe(alt_oe), .alt_out(alt_out)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] off, input logic [7:0] d);
    @(negedge clk);
    reg_off = off; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] off, output logic [7:0] d);
    @(negedge clk);
    reg_off = off;
    #1 d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v); check("R1 index", v, 8'h00);
    rd(2'd3, v); check("R1 outdata", v, 8'h00);
    rd(2'd1, v); check("R1 window", v, 8'h00);
    check("R1 oe", pin_oe, 8'h00);
    wr(2'd0, 8'h01);
    rd(2'd1, v); check("R1 dir", v, 8'hFF);
  endtask

  task automatic t_index();
    logic [7:0] v;
    wr(2'd0, 8'h5A); rd(2'd0, v); check("R2 index", v, 8'h5A);
    wr(2'd0, 8'h01); rd(2'd0, v); check("R2 index", v, 8'h01);
  endtask

  task automatic t_dir();
    logic [7:0] v;
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h0F); rd(2'd1, v); check("R3 dir", v, 8'h0F);
    check("R3 oe", pin_oe, 8'hF0);
  endtask

  task automatic t_unimpl();
    logic [7:0] v;
    wr(2'd0, 8'h02);
    wr(2'd1, 8'hAA); rd(2'd1, v); check("R4 read zero", v, 8'h00);
    check("R4 oe unchanged", pin_oe, 8'hF0);
    wr(2'd0, 8'h00); wr(2'd1, 8'h33);
    wr(2'd0, 8'h01); rd(2'd1, v); check("R4 dir kept", v, 8'h0F);
  endtask

  task automatic t_drive();
    logic [7:0] v;
    wr(2'd3, 8'hC3); rd(2'd3, v); check("R9 outdata", v, 8'hC3);
    check("R5 out", pin_out & pin_oe, 8'hC0);
    check("R5 oe", pin_oe, 8'hF0);
    wr(2'd1, 8'hFF); check("R6 oe", pin_oe, 8'h00);
    wr(2'd1, 8'h00); check("R5 all out", pin_out, 8'hC3);
    check("R5 all oe", pin_oe, 8'hFF);
  endtask

  task automatic t_alt();
    @(negedge clk);
    wr(2'd1, 8'hF0);
    alt_en = 8'h3C; alt_oe = 8'h24; alt_out = 8'h18;
    #1;
    check("R7 oe", pin_oe, 8'h27);
    check("R7 out", pin_out & 8'h3C, 8'h18);
    alt_en = 8'h00;
    #1 check("R7 release", pin_oe, 8'h0F);
  endtask

  task automatic t_input();
    logic [7:0] v;
    @(negedge clk); pin_in = 8'h96;
    @(negedge clk); @(negedge clk);
    reg_off = 2'd2; #1 check("R8 two edges", reg_rdata, 8'h00);
    @(negedge clk); #1 check("R8 three edges", reg_rdata, 8'h96);
    wr(2'd2, 8'h11); rd(2'd2, v); check("R8 read-only", v, 8'h96);
    rd(2'd3, v); check("R8 outdata kept", v, 8'hC3);
    rd(2'd0, v); check("R8 index kept", v, 8'h01);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_off = 2'd0; reg_wdata = 8'h00;
    pin_in = 8'h00; alt_en = 8'h00; alt_oe = 8'h00; alt_out = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_index();
    t_dir();
    t_unimpl();
    t_drive();
    t_alt();
    t_input();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule